// File: doc/BRIEF.md
# Store Buffer with Early Ownership Requests

This block queues core stores in front of a write-back coherent cache. A store the buffer accepts starts, in the very next cycle, a request for exclusive ownership of its cache line toward the coherence controller. The core does not stall while ownership is being acquired: it can keep issuing stores until every slot is in use. Address, data and byte mask wait in the slot. A slot is written into the cache only when it is the oldest one, its line is owned and the cache write port is ready. The slot is then released for a new store.

Two more services sit beside the queue. A combinational load lookup merges buffered bytes over the data the cache supplies, so a core load sees its own pending stores. A barrier input stops new stores and reports completion once every pending store has reached the cache. Only one ownership request per line is ever outstanding. A grant for a line makes every buffered store to that line eligible to drain.

Top module: `store_own_buffer`

## Requirements
- R1: After reset the buffer is empty. `st_ready` is 1, `own_req_valid` is 0, `wr_valid` is 0, `bar_done` is 0, and `ld_fwd_mask` is 0 for any load address.
- R2: An accepted store whose line (address bits [15:4]) matches no buffered store and is not granted in the same cycle drives `own_req_valid` with that line from the following cycle. When several lines are waiting, the oldest waiting store's line is offered first.
- R3: At most one ownership request per line is outstanding. A store accepted while an older buffered store to the same line exists sends no new request. It inherits that line's ownership state: held if already owned, otherwise waiting.
- R4: `wr_valid` is high exactly when the oldest buffered store holds ownership. `wr_addr`, `wr_data` and `wr_mask` then carry that store unchanged, and they stay stable while `wr_ready` is low.
- R5: Stores are written to the cache in acceptance order, even when a younger store's line is granted first.
- R6: A slot is freed in the cycle `wr_valid && wr_ready`. `st_ready` is 0 whenever all DEPTH slots are occupied.
- R7: For a load word address (bits [15:2]), each byte lane `b` of `ld_data` comes from the youngest buffered store to that word whose mask bit `b` is set, and from `ld_cache_data` otherwise. `ld_fwd_mask[b]` is 1 exactly when the lane was forwarded.
- R8: While `bar_req` is 1, `st_ready` is 0. `bar_done` equals `bar_req` and buffer-empty.
- R9: A grant on `own_grant_line` gives ownership to every buffered store on that line, including a store accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | 16 | Store byte address, word aligned |
| st_data | input | 32 | Store data |
| st_mask | input | 4 | Store byte enables |
| ld_addr | input | 16 | Load lookup address |
| ld_cache_data | input | 32 | Cache data for the load word |
| ld_data | output | 32 | Load data merged with buffered bytes |
| ld_fwd_mask | output | 4 | Byte lanes taken from the buffer |
| own_req_valid | output | 1 | Ownership request offered |
| own_req_line | output | 12 | Line address of the request |
| own_req_ready | input | 1 | Controller accepts the request |
| own_grant_valid | input | 1 | Ownership granted |
| own_grant_line | input | 12 | Line that was granted |
| wr_valid | output | 1 | Cache write offered |
| wr_addr | output | 16 | Cache write address |
| wr_data | output | 32 | Cache write data |
| wr_mask | output | 4 | Cache write byte enables |
| wr_ready | input | 1 | Cache accepts the write |
| bar_req | input | 1 | Barrier requested |
| bar_done | output | 1 | Barrier complete, buffer empty |

## Verification
Several of the block's functions can fall in the same cycle: a store is accepted while its line is granted, or while the oldest slot drains. The state the new slot takes then depends on which of these is seen first. The random phase provokes these collisions by running stores, grants, request acceptance and cache readiness at independent random rates over a small pool of lines. The grant responder sometimes answers a younger request before an older one. Each collision is judged against a bench model that decides the new slot's ownership from the slots live at the start of the cycle plus that cycle's grant. The model then checks the following request, the drain order and the forwarded bytes.

// File: rtl/sob_pkg.sv
package sob_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int BYTES      = DATA_W / 8;
    localparam int OFF_W      = $clog2(BYTES);
    localparam int LINE_OFF_W = 4;
    localparam int LINE_W     = ADDR_W - LINE_OFF_W;
    localparam int WORD_W     = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        OWN_NEED = 2'd0,
        OWN_WAIT = 2'd1,
        OWN_HELD = 2'd2
    } own_t;

    typedef struct packed {
        logic                vld;
        own_t                own;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [BYTES-1:0]    mask;
    } sb_ent_t;

    function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:LINE_OFF_W];
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

endpackage

// File: rtl/sob_pick.sv
module sob_pick #(
    parameter int DEPTH = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] cand,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Oldest candidate by age relative to head (DEPTH is a power of two).
    always_comb begin
        found = 1'b0;
        idx   = head;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDX_W-1:0] p;
            p = head + IDX_W'(k);
            if (!found && cand[p]) begin
                found = 1'b1;
                idx   = p;
            end
        end
    end

    // R2: a chosen slot is always a candidate, and candidates are never missed
    a_r2_pick_valid: assert property (@(posedge clk) disable iff (rst)
        (found |-> cand[idx]) and ((cand != '0) |-> found));

endmodule

// File: rtl/sob_fwd.sv
module sob_fwd
    import sob_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  sb_ent_t           ents [DEPTH],
    input  logic [IDX_W-1:0]  head,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] cache_data,
    output logic [DATA_W-1:0] ld_data,
    output logic [BYTES-1:0]  fwd_mask
);
    logic [DEPTH-1:0] word_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign word_hit[i] = ents[i].vld && (word_of(ents[i].addr) == word_of(ld_addr));
    end

    // Per byte lane, walk oldest to youngest so the youngest match wins.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        always_comb begin
            ld_data[8*b +: 8] = cache_data[8*b +: 8];
            fwd_mask[b]       = 1'b0;
            for (int k = 0; k < DEPTH; k++) begin
                logic [IDX_W-1:0] p;
                p = head + IDX_W'(k);
                if (word_hit[p] && ents[p].mask[b]) begin
                    ld_data[8*b +: 8] = ents[p].data[8*b +: 8];
                    fwd_mask[b]       = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/store_own_buffer.sv
module store_own_buffer
    import sob_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BYTES-1:0]  st_mask,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_cache_data,
    output logic [DATA_W-1:0] ld_data,
    output logic [BYTES-1:0]  ld_fwd_mask,
    output logic              own_req_valid,
    output logic [LINE_W-1:0] own_req_line,
    input  logic              own_req_ready,
    input  logic              own_grant_valid,
    input  logic [LINE_W-1:0] own_grant_line,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [BYTES-1:0]  wr_mask,
    input  logic              wr_ready,
    input  logic              bar_req,
    output logic              bar_done
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_ent_t          ents [DEPTH];
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    logic             full, push, pop, req_fire, req_found;
    logic [IDX_W-1:0] req_idx;
    logic [DEPTH-1:0] need_vec;
    sb_ent_t          head_e, new_ent;

    // ---------------- core store port ----------------
    assign full     = (count_q == CNT_W'(DEPTH));
    assign st_ready = !full && !bar_req;
    assign push     = st_valid && st_ready;

    // ---------------- drain ----------------
    assign head_e   = ents[head_q];
    assign wr_valid = head_e.vld && (head_e.own == OWN_HELD);
    assign wr_addr  = head_e.addr;
    assign wr_data  = head_e.data;
    assign wr_mask  = head_e.mask;
    assign pop      = wr_valid && wr_ready;

    assign bar_done = bar_req && (count_q == '0);

    // ---------------- ownership requests ----------------
    for (genvar i = 0; i < DEPTH; i++) begin : g_need
        assign need_vec[i] = ents[i].vld && (ents[i].own == OWN_NEED);
    end

    sob_pick #(.DEPTH(DEPTH)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .cand  (need_vec),
        .head  (head_q),
        .found (req_found),
        .idx   (req_idx)
    );

    assign own_req_valid = req_found;
    assign own_req_line  = line_of(ents[req_idx].addr);
    assign req_fire      = own_req_valid && own_req_ready;

    // New slot inherits the ownership state of its line.
    always_comb begin
        logic any_live, any_held;
        any_live = 1'b0;
        any_held = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ents[i].vld && line_of(ents[i].addr) == line_of(st_addr)) begin
                any_live = 1'b1;
                if (ents[i].own == OWN_HELD) any_held = 1'b1;
            end
        end
        new_ent.vld  = 1'b1;
        new_ent.addr = st_addr;
        new_ent.data = st_data;
        new_ent.mask = st_mask;
        if ((own_grant_valid && own_grant_line == line_of(st_addr)) || any_held)
            new_ent.own = OWN_HELD;
        else if (any_live)
            new_ent.own = OWN_WAIT;
        else
            new_ent.own = OWN_NEED;
    end

    // ---------------- slot state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (req_fire && IDX_W'(i) == req_idx)
                    ents[i].own <= OWN_WAIT;
                if (own_grant_valid && ents[i].vld &&
                    line_of(ents[i].addr) == own_grant_line)
                    ents[i].own <= OWN_HELD;
                if (pop && IDX_W'(i) == head_q)
                    ents[i].vld <= 1'b0;
                if (push && IDX_W'(i) == tail_q)
                    ents[i] <= new_ent;
            end
            if (pop)  head_q <= head_q + 1'b1;
            if (push) tail_q <= tail_q + 1'b1;
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // ---------------- load forwarding ----------------
    sob_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ents       (ents),
        .head       (head_q),
        .ld_addr    (ld_addr),
        .cache_data (ld_cache_data),
        .ld_data    (ld_data),
        .fwd_mask   (ld_fwd_mask)
    );

    // ---------------- assertions ----------------
    // R3: a line just requested is not offered again next cycle
    a_r3_one_request: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> !(own_req_valid && own_req_line == $past(own_req_line)));

    // R4: a stalled cache write holds its payload
    a_r4_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                     $stable(wr_data) && $stable(wr_mask)));

    // R5: each drain advances the oldest slot by exactly one
    a_r5_in_order: assert property (@(posedge clk) disable iff (rst)
        pop |=> (head_q == $past(head_q) + 1'b1));

    // R6: occupancy never exceeds the slot count
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R8: a completed barrier leaves nothing to request or write
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        bar_done |-> (!wr_valid && !own_req_valid));

endmodule

// File: tb/tb_store_own_buffer.sv
`timescale 1ns/1ps
module tb_store_own_buffer;
    import sob_pkg::*;

    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic              st_valid, st_ready;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic [BYTES-1:0]  st_mask;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_cache_data, ld_data;
    logic [BYTES-1:0]  ld_fwd_mask;
    logic              own_req_valid, own_req_ready, own_grant_valid;
    logic [LINE_W-1:0] own_req_line, own_grant_line;
    logic              wr_valid, wr_ready;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [BYTES-1:0]  wr_mask;
    logic              bar_req, bar_done;

    store_own_buffer #(.DEPTH(DEPTH)) dut (.*);

    // ---------------- bench model ----------------
    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [BYTES-1:0]  m;
        int                st;   // 0 needs request, 1 waiting, 2 held
    } me_t;

    me_t mq[$];
    int  ol[$];   // outstanding requested lines
    int  oa[$];   // their ages

    int n_cmp = 0, n_bad = 0;
    int req_cnt = 0, wr_cnt = 0;
    int gmode = 1;

    logic              d_st_valid, d_req_ready, d_wr_ready, d_bar;
    logic [ADDR_W-1:0] d_st_addr, d_ld_addr;
    logic [DATA_W-1:0] d_st_data, d_cache;
    logic [BYTES-1:0]  d_st_mask;

    function automatic int lof(input logic [ADDR_W-1:0] a);
        return int'(a[ADDR_W-1:LINE_OFF_W]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W+BYTES-1:0] exp_fwd(input logic [ADDR_W-1:0] la,
                                                        input logic [DATA_W-1:0] cd);
        logic [DATA_W-1:0] d;
        logic [BYTES-1:0]  m;
        d = cd;
        m = '0;
        foreach (mq[i])
            if (mq[i].a[ADDR_W-1:OFF_W] == la[ADDR_W-1:OFF_W])
                for (int b = 0; b < BYTES; b++)
                    if (mq[i].m[b]) begin
                        d[8*b +: 8] = mq[i].d[8*b +: 8];
                        m[b] = 1'b1;
                    end
        return {m, d};
    endfunction

    task automatic step();
        int  g, need_i, nst;
        bit  gv, acc;
        logic [DATA_W+BYTES-1:0] ef;
        @(negedge clk);
        // choose a grant among outstanding requests
        gv = 1'b0; g = 0;
        if (gmode == 1) begin
            foreach (ol[k]) if (!gv && oa[k] >= 1) begin gv = 1'b1; g = k; end
        end else if (gmode == 2 && ol.size() > 0 && $urandom_range(0, 1) == 1) begin
            int k;
            k = $urandom_range(0, ol.size() - 1);
            if (oa[k] >= 1) begin gv = 1'b1; g = k; end
        end
        st_valid = d_st_valid; st_addr = d_st_addr; st_data = d_st_data; st_mask = d_st_mask;
        ld_addr = d_ld_addr; ld_cache_data = d_cache;
        own_req_ready = d_req_ready; wr_ready = d_wr_ready; bar_req = d_bar;
        own_grant_valid = gv;
        own_grant_line  = gv ? LINE_W'(ol[g]) : '0;
        #1;
        // ---- checks against start-of-cycle model ----
        chk(st_ready == (mq.size() < DEPTH && !d_bar), "R6/R8 st_ready", 64'(st_ready),
            64'(mq.size() < DEPTH && !d_bar));
        chk(bar_done == (d_bar && mq.size() == 0), "R8 bar_done", 64'(bar_done),
            64'(d_bar && mq.size() == 0));
        ef = exp_fwd(d_ld_addr, d_cache);
        chk({ld_fwd_mask, ld_data} == ef, "R7 forward", 64'({ld_fwd_mask, ld_data}), 64'(ef));
        if (mq.size() > 0 && mq[0].st == 2) begin
            chk(wr_valid == 1'b1, "R4 head owned drains", 64'(wr_valid), 64'd1);
            chk({wr_addr, wr_data, wr_mask} == {mq[0].a, mq[0].d, mq[0].m}, "R5 drain order",
                64'({wr_addr, wr_data, wr_mask}), 64'({mq[0].a, mq[0].d, mq[0].m}));
        end else
            chk(wr_valid == 1'b0, "R4 no write unowned", 64'(wr_valid), 64'd0);
        need_i = -1;
        foreach (mq[i]) if (need_i < 0 && mq[i].st == 0) need_i = i;
        chk(own_req_valid == (need_i >= 0), "R2 req valid", 64'(own_req_valid), 64'(need_i >= 0));
        if (own_req_valid && need_i >= 0)
            chk(int'(own_req_line) == lof(mq[need_i].a), "R2 req line",
                64'(own_req_line), 64'(lof(mq[need_i].a)));
        // ---- events at the coming edge ----
        acc = d_st_valid && st_ready;
        nst = 0;
        if (acc) begin
            bit live, held;
            live = 0; held = 0;
            foreach (mq[i]) if (lof(mq[i].a) == lof(d_st_addr)) begin
                live = 1; if (mq[i].st == 2) held = 1;
            end
            nst = ((gv && ol[g] == lof(d_st_addr)) || held) ? 2 : (live ? 1 : 0);
        end
        if (own_req_valid && d_req_ready && need_i >= 0) begin
            foreach (ol[k])
                chk(ol[k] != int'(own_req_line), "R3 duplicate request", 64'(own_req_line), 64'(ol[k]));
            mq[need_i].st = 1;
            ol.push_back(int'(own_req_line)); oa.push_back(-1);
            req_cnt++;
        end
        if (gv) begin
            int gl;
            gl = ol[g];
            foreach (mq[i]) if (lof(mq[i].a) == gl) mq[i].st = 2;
            ol.delete(g); oa.delete(g);
        end
        foreach (oa[k]) oa[k]++;
        if (wr_valid && d_wr_ready && mq.size() > 0) begin
            void'(mq.pop_front());
            wr_cnt++;
        end
        if (acc) begin
            me_t e;
            e.a = d_st_addr; e.d = d_st_data; e.m = d_st_mask; e.st = nst;
            mq.push_back(e);
        end
    endtask

    task automatic idle_drive();
        d_st_valid = 0; d_st_addr = '0; d_st_data = '0; d_st_mask = '0;
        d_ld_addr = '0; d_cache = '0; d_req_ready = 1; d_wr_ready = 1; d_bar = 0;
    endtask

    task automatic drain_all();
        idle_drive();
        gmode = 1;
        for (int i = 0; i < 200 && (mq.size() > 0 || ol.size() > 0); i++) step();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        idle_drive();
        rst = 1;
        st_valid = 0; st_addr = '0; st_data = '0; st_mask = '0; ld_addr = '0;
        ld_cache_data = '0; own_req_ready = 0; own_grant_valid = 0; own_grant_line = '0;
        wr_ready = 0; bar_req = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk); #1;
        // R1 reset state
        chk(st_ready == 1 && own_req_valid == 0 && wr_valid == 0 && bar_done == 0 && ld_fwd_mask == 0,
            "R1 reset state", 64'({st_ready, own_req_valid, wr_valid, bar_done, ld_fwd_mask}),
            64'({1'b1, 1'b0, 1'b0, 1'b0, 4'h0}));

        // R2 directed: one store, request appears next cycle with its line
        gmode = 0;
        d_req_ready = 0;
        d_st_valid = 1; d_st_addr = 16'h0124; d_st_data = 32'hA1B2C3D4; d_st_mask = 4'hF;
        step();
        d_st_valid = 0;
        step();
        chk(own_req_valid && own_req_line == 12'h012, "R2 directed request",
            64'({own_req_valid, own_req_line}), 64'({1'b1, 12'h012}));
        // R3/R9 directed: second store to same line, one request, one grant, two writes
        d_st_valid = 1; d_st_addr = 16'h0128; d_st_data = 32'h11223344; d_st_mask = 4'h3;
        step();
        d_st_valid = 0; d_req_ready = 1;
        step();
        chk(req_cnt == 1, "R3 single request per line", 64'(req_cnt), 64'd1);
        // R7 directed: load the second word, low lanes forwarded
        d_ld_addr = 16'h0128; d_cache = 32'hFFFFFFFF;
        step();
        chk(ld_data == 32'hFFFF3344 && ld_fwd_mask == 4'h3, "R7 directed merge",
            64'({ld_fwd_mask, ld_data}), 64'({4'h3, 32'hFFFF3344}));
        gmode = 1;
        repeat (6) step();
        chk(wr_cnt == 2 && req_cnt == 1, "R9 one grant drains both", 64'({wr_cnt, req_cnt}), 64'({32'd2, 32'd1}));

        // R5 directed: grant younger line first, head must not drain
        gmode = 0; wr_cnt = 0;
        d_st_valid = 1; d_st_addr = 16'h0200; d_st_data = 32'h0A0A0A0A; d_st_mask = 4'hF;
        step();
        d_st_addr = 16'h0300; d_st_data = 32'h0B0B0B0B;
        step();
        d_st_valid = 0;
        repeat (3) step();
        gmode = 3;
        begin : grant_young
            own_grant_valid = 0;
        end
        // grant the younger line by hand through the model's outstanding list
        if (ol.size() == 2) begin
            int t; t = ol[0]; ol[0] = ol[1]; ol[1] = t;
        end
        gmode = 1;
        d_wr_ready = 1;
        step();  // grants younger line (now first in list)
        gmode = 0;
        step();
        chk(wr_valid == 0 && wr_cnt == 0, "R5 younger owned, older blocks", 64'({wr_valid, wr_cnt}), 64'd0);
        drain_all();
        chk(wr_cnt == 2, "R5 both drained", 64'(wr_cnt), 64'd2);

        // R6 directed: fill without grants, port must stall
        gmode = 0; d_req_ready = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            d_st_valid = 1; d_st_addr = 16'(16'h0400 + 16'(i * 4)); d_st_data = 32'(i); d_st_mask = 4'h1;
            step();
        end
        chk(mq.size() == DEPTH && st_ready == 0, "R6 full stalls", 64'({mq.size(), st_ready}),
            64'({32'(DEPTH), 1'b0}));
        drain_all();

        // random phase
        gmode = 2;
        for (int c = 0; c < 4000; c++) begin
            d_st_valid  = ($urandom_range(0, 9) < 6);
            d_st_addr   = 16'h0100 | 16'($urandom_range(0, 3) << 4) | 16'($urandom_range(0, 3) << 2);
            d_st_data   = $urandom;
            d_st_mask   = 4'($urandom_range(1, 15));
            d_ld_addr   = 16'h0100 | 16'($urandom_range(0, 3) << 4) | 16'($urandom_range(0, 3) << 2);
            d_cache     = $urandom;
            d_req_ready = ($urandom_range(0, 9) < 7);
            d_wr_ready  = ($urandom_range(0, 9) < 7);
            d_bar       = ($urandom_range(0, 19) == 0);
            step();
        end

        // R8 barrier with stores still offered
        gmode = 1; d_req_ready = 1; d_wr_ready = 1;
        d_bar = 1; d_st_valid = 1;
        for (int i = 0; i < 200 && !(bar_done && mq.size() == 0); i++) step();
        chk(bar_done == 1 && mq.size() == 0, "R8 barrier completes empty",
            64'({bar_done, mq.size()}), 64'({1'b1, 32'd0}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule